// File: doc/BRIEF.md
# Stack-Top Line Buffer

This block sits beside a processor core and holds the few cache lines that cover the top of that core's stack. Loads and stores that the core marks as stack accesses are served from these private lines. The shared L1 cache is reached only when a line has to be brought in, when a modified line is pushed out to make room, or when a process switch hands the stack over. Private stack traffic therefore causes no coherence broadcasts.

Each line is 128 bits wide and there are four line slots. Every slot has a valid bit, a dirty bit and a line tag. The line tag is the address with its low four bits dropped. When a miss finds no free slot, the slot whose line lies farthest from the current stack pointer is reused. Reloading the stack pointer marks a context change. On that event every modified line is written back and the whole buffer is emptied. The core is stalled whenever the buffer is busy with L1.

Top module: `stack_top_buffer`

## Requirements
- R1: After reset every slot is invalid and neither L1 request is raised. With no core request, `coreStall` is low, and the first stack access is a miss.
- R2: A read whose line is held in a valid slot completes in the same cycle with `coreStall` low. `coreRdata` is the 32-bit word selected by `coreAddr[3:2]`, where word 0 is bits 31:0 of the line.
- R3: A write that hits completes without stalling. It changes only the bytes whose `coreBe` bit is set, with bit j selecting byte j (bits 8j+7:8j) of the addressed word. It marks the slot dirty and causes no L1 read or write.
- R4: A miss stalls the core and raises `l1RdReq` with `l1RdAddr` equal to the access address with its low 4 bits cleared, until `l1RdValid`. The returned line goes into the lowest-numbered invalid slot, and the access then completes from the buffer.
- R5: When all slots are valid, a miss reuses the slot whose line tag differs most (in absolute value) from the tag of `spIn`, with ties going to the lower slot number. A dirty victim is written back with its own line address and contents before the fill starts. A clean victim is dropped without a write.
- R6: A write-back holds `l1WrReq`, its address and its data until `l1WrReady` is seen. The core stays stalled throughout. `l1WrReq` and `l1RdReq` are never high together.
- R7: A one-cycle `spReload` pulse stalls the core while every dirty slot is written back, in ascending slot order, with clean slots skipped. After that all slots are invalid, so a later access to a previously held line misses.
- R8: A `spReload` pulse that arrives while a miss is in progress is not lost. The flush of R7 runs after the fill, and the stalled access completes only afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coreReq | input | 1 | Core stack access request, held until not stalled |
| coreWe | input | 1 | 1 = write, 0 = read |
| coreAddr | input | 32 | Byte address of the access |
| coreBe | input | 4 | Byte enables within the addressed word |
| coreWdata | input | 32 | Write data |
| coreRdata | output | 32 | Read data, valid when request is high and stall low |
| coreStall | output | 1 | Access cannot complete this cycle |
| spIn | input | 32 | Current stack pointer |
| spReload | input | 1 | Stack pointer reload / context switch strobe |
| l1RdReq | output | 1 | Line fill request to L1 |
| l1RdAddr | output | 32 | Line address of the fill |
| l1RdValid | input | 1 | Fill data valid, ends the fill |
| l1RdData | input | 128 | Fill line data |
| l1WrReq | output | 1 | Line write-back request to L1 |
| l1WrAddr | output | 32 | Line address of the write-back |
| l1WrData | output | 128 | Line data of the write-back |
| l1WrReady | input | 1 | L1 accepts the write-back this cycle |

## Verification
A hit returns its read data in the cycle of the request, and a hit write takes effect at the next rising edge. The bench drives each access just after a falling edge and samples `coreStall` and `coreRdata` one nanosecond later. It then samples again after each further falling edge until the stall drops. A miss takes one cycle to enter its L1 phase, one cycle per write-back and fill beat, and one more cycle to return to idle. The bench therefore measures stall length only as a lower bound set by its own L1 response latencies. It checks write-back order and contents from a log its L1 model keeps at the moment it raises ready.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // strobes from the control FSM to the slot datapath
  typedef struct packed {
    logic wrHit;     // merge core write into the hit slot
    logic fillLoad;  // load fill line into slotSel, valid and clean
    logic cleanSel;  // slotSel has been written back, clear dirty
    logic invalAll;  // end of context flush, drop every slot
  } sbCtrlT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_FLUSH
  } sbStateT;

endpackage

// File: rtl/sb_datapath.sv
module sb_datapath
  import sb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int DATA_W = 32,
  parameter int SLOTS  = 4,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int WORDS  = LINE_W / DATA_W,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbCtrlT            ctrl,
  input  logic [SLOT_W-1:0] slotSel,
  input  logic [TAG_W-1:0]  fillTag,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [BE_W-1:0]   coreBe,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [ADDR_W-1:0] spIn,
  output logic              hit,
  output logic [SLOT_W-1:0] hitIdx,
  output logic              anyFree,
  output logic [SLOT_W-1:0] freeIdx,
  output logic [SLOT_W-1:0] victimIdx,
  output logic              victimDirty,
  output logic              selValid,
  output logic              selDirty,
  output logic [TAG_W-1:0]  selTag,
  output logic [LINE_W-1:0] selLine,
  output logic [DATA_W-1:0] coreRdata
);

  logic [SLOTS-1:0]  validQ;
  logic [SLOTS-1:0]  dirtyQ;
  logic [TAG_W-1:0]  tagQ  [SLOTS];
  logic [LINE_W-1:0] lineQ [SLOTS];
  logic [SLOTS-1:0]  hitVec;
  logic [TAG_W-1:0]  distV [SLOTS];
  logic [TAG_W-1:0]  bestDist;
  logic [TAG_W-1:0]  coreTag;
  logic [TAG_W-1:0]  spTag;
  logic [WSEL_W-1:0] wordSel;

  assign coreTag = coreAddr[ADDR_W-1:OFF_W];
  assign spTag   = spIn[ADDR_W-1:OFF_W];
  assign wordSel = coreAddr[OFF_W-1:OFF_W-WSEL_W];

  // per-slot match and distance from the stack pointer line
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    assign hitVec[g] = validQ[g] && (tagQ[g] == coreTag);
    assign distV[g]  = (tagQ[g] >= spTag) ? (tagQ[g] - spTag) : (spTag - tagQ[g]);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (hitVec[i]) hitIdx = SLOT_W'(i);
    end
  end
  assign hit = |hitVec;

  // lowest free slot: scan downward so the last match wins
  always_comb begin
    freeIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!validQ[i]) freeIdx = SLOT_W'(i);
    end
  end
  assign anyFree = ~&validQ;

  // farthest line wins, strict compare keeps the lower slot on ties
  always_comb begin
    victimIdx = '0;
    bestDist  = distV[0];
    for (int i = 1; i < SLOTS; i++) begin
      if (distV[i] > bestDist) begin
        bestDist  = distV[i];
        victimIdx = SLOT_W'(i);
      end
    end
  end
  assign victimDirty = dirtyQ[victimIdx];

  assign selValid  = validQ[slotSel];
  assign selDirty  = dirtyQ[slotSel];
  assign selTag    = tagQ[slotSel];
  assign selLine   = lineQ[slotSel];
  assign coreRdata = lineQ[hitIdx][int'(wordSel)*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      if (ctrl.invalAll) begin
        validQ <= '0;
        dirtyQ <= '0;
      end
      if (ctrl.fillLoad) begin
        validQ[slotSel] <= 1'b1;
        dirtyQ[slotSel] <= 1'b0;
      end
      if (ctrl.cleanSel) dirtyQ[slotSel] <= 1'b0;
      if (ctrl.wrHit)    dirtyQ[hitIdx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.fillLoad) begin
      tagQ[slotSel]  <= fillTag;
      lineQ[slotSel] <= fillLine;
    end
    if (ctrl.wrHit) begin
      for (int b = 0; b < BE_W; b++) begin
        if (coreBe[b]) lineQ[hitIdx][int'(wordSel)*DATA_W + b*8 +: 8] <= coreWdata[b*8 +: 8];
      end
    end
  end

  // R2: a line may sit in at most one slot
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R3: a merged write leaves its slot dirty
  a_r3_write_dirty: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrHit |=> dirtyQ[$past(hitIdx)]);

  // R4: a freshly filled slot is valid and clean
  a_r4_fill_clean: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.fillLoad |=> (validQ[$past(slotSel)] && !dirtyQ[$past(slotSel)]));

  // R7: the end of a flush empties the buffer
  a_r7_all_invalid: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.invalAll |=> (validQ == '0));

endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int TAG_W = 28,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [TAG_W-1:0]  coreTag,
  input  logic              spReload,
  input  logic              hit,
  input  logic [SLOT_W-1:0] hitIdx,
  input  logic              anyFree,
  input  logic [SLOT_W-1:0] freeIdx,
  input  logic [SLOT_W-1:0] victimIdx,
  input  logic              victimDirty,
  input  logic              selValid,
  input  logic              selDirty,
  input  logic              l1WrReady,
  input  logic              l1RdValid,
  output sbCtrlT            ctrl,
  output logic [SLOT_W-1:0] slotSel,
  output logic [TAG_W-1:0]  fillTag,
  output logic              coreStall,
  output logic              l1WrReq,
  output logic              l1RdReq
);

  sbStateT           stateQ, stateD;
  logic [SLOT_W-1:0] tgtQ, tgtD;
  logic [TAG_W-1:0]  missTagQ, missTagD;
  logic [SLOT_W-1:0] flushIdxQ, flushIdxD;
  logic              flushPendQ, flushPendD;
  logic              goFlush;
  logic              flushWr;
  logic              isIdle;

  assign isIdle  = (stateQ == ST_IDLE);
  assign goFlush = flushPendQ || spReload;
  assign flushWr = selValid && selDirty;
  assign fillTag = missTagQ;

  always_comb begin
    unique case (stateQ)
      ST_EVICT, ST_FILL: slotSel = tgtQ;
      ST_FLUSH:          slotSel = flushIdxQ;
      default:           slotSel = hitIdx;
    endcase
  end

  assign l1WrReq   = (stateQ == ST_EVICT) || ((stateQ == ST_FLUSH) && flushWr);
  assign l1RdReq   = (stateQ == ST_FILL);
  assign coreStall = coreReq && !(isIdle && hit && !goFlush);

  always_comb begin
    stateD     = stateQ;
    tgtD       = tgtQ;
    missTagD   = missTagQ;
    flushIdxD  = flushIdxQ;
    flushPendD = flushPendQ || (spReload && !isIdle);
    ctrl       = '0;
    ctrl.cleanSel = l1WrReq && l1WrReady;
    unique case (stateQ)
      ST_IDLE: begin
        if (goFlush) begin
          stateD     = ST_FLUSH;
          flushIdxD  = '0;
          flushPendD = 1'b0;
        end else if (coreReq && !hit) begin
          missTagD = coreTag;
          tgtD     = anyFree ? freeIdx : victimIdx;
          stateD   = (!anyFree && victimDirty) ? ST_EVICT : ST_FILL;
        end else if (coreReq && coreWe) begin
          ctrl.wrHit = 1'b1;
        end
      end
      ST_EVICT: begin
        if (l1WrReady) stateD = ST_FILL;
      end
      ST_FILL: begin
        if (l1RdValid) begin
          ctrl.fillLoad = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        if (!flushWr || l1WrReady) begin
          if (flushIdxQ == SLOT_W'(SLOTS - 1)) begin
            ctrl.invalAll = 1'b1;
            stateD        = ST_IDLE;
          end else begin
            flushIdxD = flushIdxQ + 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      tgtQ       <= '0;
      missTagQ   <= '0;
      flushIdxQ  <= '0;
      flushPendQ <= 1'b0;
    end else begin
      stateQ     <= stateD;
      tgtQ       <= tgtD;
      missTagQ   <= missTagD;
      flushIdxQ  <= flushIdxD;
      flushPendQ <= flushPendD;
    end
  end

  // R6: fill and write-back never share a cycle
  a_r6_one_port: assert property (@(posedge clk) disable iff (!rstN)
    !(l1WrReq && l1RdReq));

  // R6: an unaccepted write-back keeps its slot and stays raised
  a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rstN)
    (l1WrReq && !l1WrReady) |=> (l1WrReq && $stable(slotSel)));

  // R4: an unanswered fill stays raised with the same line
  a_r4_fill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (l1RdReq && !l1RdValid) |=> (l1RdReq && $stable(fillTag)));

  // R4: any request while busy with L1 is stalled
  a_r4_stall_busy: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && !isIdle) |-> coreStall);

endmodule

// File: rtl/stack_top_buffer.sv
module stack_top_buffer
  import sb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int DATA_W = 32,
  parameter int SLOTS  = 4,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreReq,
  input  logic              coreWe,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [BE_W-1:0]   coreBe,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] coreRdata,
  output logic              coreStall,
  input  logic [ADDR_W-1:0] spIn,
  input  logic              spReload,
  output logic              l1RdReq,
  output logic [ADDR_W-1:0] l1RdAddr,
  input  logic              l1RdValid,
  input  logic [LINE_W-1:0] l1RdData,
  output logic              l1WrReq,
  output logic [ADDR_W-1:0] l1WrAddr,
  output logic [LINE_W-1:0] l1WrData,
  input  logic              l1WrReady
);

  sbCtrlT            ctrl;
  logic [SLOT_W-1:0] slotSel;
  logic [TAG_W-1:0]  fillTag;
  logic              hit;
  logic [SLOT_W-1:0] hitIdx;
  logic              anyFree;
  logic [SLOT_W-1:0] freeIdx;
  logic [SLOT_W-1:0] victimIdx;
  logic              victimDirty;
  logic              selValid;
  logic              selDirty;
  logic [TAG_W-1:0]  selTag;

  sb_control #(
    .SLOTS(SLOTS),
    .TAG_W(TAG_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .coreReq    (coreReq),
    .coreWe     (coreWe),
    .coreTag    (coreAddr[ADDR_W-1:OFF_W]),
    .spReload   (spReload),
    .hit        (hit),
    .hitIdx     (hitIdx),
    .anyFree    (anyFree),
    .freeIdx    (freeIdx),
    .victimIdx  (victimIdx),
    .victimDirty(victimDirty),
    .selValid   (selValid),
    .selDirty   (selDirty),
    .l1WrReady  (l1WrReady),
    .l1RdValid  (l1RdValid),
    .ctrl       (ctrl),
    .slotSel    (slotSel),
    .fillTag    (fillTag),
    .coreStall  (coreStall),
    .l1WrReq    (l1WrReq),
    .l1RdReq    (l1RdReq)
  );

  sb_datapath #(
    .ADDR_W(ADDR_W),
    .LINE_W(LINE_W),
    .DATA_W(DATA_W),
    .SLOTS (SLOTS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .slotSel    (slotSel),
    .fillTag    (fillTag),
    .fillLine   (l1RdData),
    .coreAddr   (coreAddr),
    .coreBe     (coreBe),
    .coreWdata  (coreWdata),
    .spIn       (spIn),
    .hit        (hit),
    .hitIdx     (hitIdx),
    .anyFree    (anyFree),
    .freeIdx    (freeIdx),
    .victimIdx  (victimIdx),
    .victimDirty(victimDirty),
    .selValid   (selValid),
    .selDirty   (selDirty),
    .selTag     (selTag),
    .selLine    (l1WrData),
    .coreRdata  (coreRdata)
  );

  assign l1RdAddr = {fillTag, {OFF_W{1'b0}}};
  assign l1WrAddr = {selTag, {OFF_W{1'b0}}};

  // R1: nothing goes to L1 in the first cycle out of reset
  a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!l1RdReq && !l1WrReq));

endmodule

// File: tb/stack_top_buffer_tb.sv
module stack_top_buffer_tb_top;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         coreReq = 1'b0;
  logic         coreWe = 1'b0;
  logic [31:0]  coreAddr = '0;
  logic [3:0]   coreBe = '0;
  logic [31:0]  coreWdata = '0;
  logic [31:0]  coreRdata;
  logic         coreStall;
  logic [31:0]  spIn = 32'h0000_1000;
  logic         spReload = 1'b0;
  logic         l1RdReq;
  logic [31:0]  l1RdAddr;
  logic         l1RdValid = 1'b0;
  logic [127:0] l1RdData = '0;
  logic         l1WrReq;
  logic [31:0]  l1WrAddr;
  logic [127:0] l1WrData;
  logic         l1WrReady = 1'b0;

  always #4 clk = ~clk;

  stack_top_buffer dut_i (
    .clk(clk), .rstN(rstN), .coreReq(coreReq), .coreWe(coreWe), .coreAddr(coreAddr),
    .coreBe(coreBe), .coreWdata(coreWdata), .coreRdata(coreRdata), .coreStall(coreStall),
    .spIn(spIn), .spReload(spReload), .l1RdReq(l1RdReq), .l1RdAddr(l1RdAddr),
    .l1RdValid(l1RdValid), .l1RdData(l1RdData), .l1WrReq(l1WrReq), .l1WrAddr(l1WrAddr),
    .l1WrData(l1WrData), .l1WrReady(l1WrReady)
  );

  int tests = 0;
  int fails = 0;
  int rdLat = 1;
  int wrLat = 1;
  int rdCnt = 0;
  int wrCnt = 0;
  int fillCount = 0;
  int logN = 0;
  logic [31:0]  logAddr [32];
  logic [127:0] logData [32];
  logic [127:0] l1Mem  [logic [31:0]];
  logic [127:0] refMem [logic [31:0]];

  function automatic logic [127:0] patt(logic [31:0] line);
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = line ^ (32'h5A00_0000 + 32'(i) * 32'h0101_0101);
    return v;
  endfunction

  function automatic logic [127:0] refLine(logic [31:0] line);
    if (refMem.exists(line)) return refMem[line];
    return patt(line);
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // L1 model: answers after its latency, logs write-backs when ready is raised
  initial begin
    forever begin
      @(negedge clk);
      if (l1RdValid) begin
        l1RdValid = 1'b0;
        rdCnt = 0;
      end else if (l1RdReq) begin
        if (rdCnt >= rdLat) begin
          l1RdData  = l1Mem.exists(l1RdAddr) ? l1Mem[l1RdAddr] : patt(l1RdAddr);
          l1RdValid = 1'b1;
          fillCount++;
        end else rdCnt++;
      end
      if (l1WrReady) begin
        l1WrReady = 1'b0;
        wrCnt = 0;
      end else if (l1WrReq) begin
        if (wrCnt >= wrLat) begin
          l1WrReady = 1'b1;
          if (logN < 32) begin
            logAddr[logN] = l1WrAddr;
            logData[logN] = l1WrData;
          end
          logN++;
          l1Mem[l1WrAddr] = l1WrData;
        end else wrCnt++;
      end
    end
  end

  task automatic doOp(input logic we, input logic [31:0] addr, input logic [3:0] be,
                      input logic [31:0] wd, output int stallCyc, output logic [31:0] rd);
    @(negedge clk);
    coreReq = 1'b1; coreWe = we; coreAddr = addr; coreBe = be; coreWdata = wd;
    stallCyc = 0;
    #1;
    while (coreStall && stallCyc < 2000) begin
      @(negedge clk);
      #1;
      stallCyc++;
    end
    rd = coreRdata;
    @(posedge clk);
    #1;
    coreReq = 1'b0;
  endtask

  // runs one access, checks miss/hit and read data against the reference model
  task automatic runOp(input logic we, input logic [31:0] addr, input logic [3:0] be,
                       input logic [31:0] wd, input logic expMiss, input string req,
                       output int stallCyc);
    logic [31:0]  rd;
    logic [127:0] line;
    logic [31:0]  la;
    int           wi;
    int           logBefore;
    int           fillBefore;
    la = {addr[31:4], 4'h0};
    wi = int'(addr[3:2]);
    logBefore = logN;
    fillBefore = fillCount;
    doOp(we, addr, be, wd, stallCyc, rd);
    chk({req, " miss"}, 128'(stallCyc > 0), 128'(expMiss));
    line = refLine(la);
    if (we) begin
      for (int b = 0; b < 4; b++) if (be[b]) line[wi*32 + b*8 +: 8] = wd[b*8 +: 8];
      refMem[la] = line;
      if (!expMiss) begin
        chk("R3 no L1 traffic on hit write", 128'((logN - logBefore) + (fillCount - fillBefore)), 128'(0));
      end
    end else begin
      chk({req, " read data"}, 128'(rd), 128'(line[wi*32 +: 32]));
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        miss;
  } vecT;

  localparam int NVEC = 9;
  localparam vecT VEC [NVEC] = '{
    '{1'b0, 32'h0000_0FF0, 4'hF, 32'h0,          1'b1},  // R4 fill slot 0
    '{1'b0, 32'h0000_0FF4, 4'hF, 32'h0,          1'b0},  // R2 word 1
    '{1'b1, 32'h0000_0FF8, 4'h3, 32'hAAAA_BEEF, 1'b0},  // R3 low half
    '{1'b0, 32'h0000_0FF8, 4'hF, 32'h0,          1'b0},  // R3 merged read
    '{1'b1, 32'h0000_0FE0, 4'hF, 32'h1234_5678, 1'b1},  // R4 write miss slot 1
    '{1'b0, 32'h0000_0FD4, 4'hF, 32'h0,          1'b1},  // R4 slot 2
    '{1'b1, 32'h0000_0FCC, 4'h8, 32'hC3FF_FFFF, 1'b1},  // R3 top byte, slot 3
    '{1'b0, 32'h0000_0FCC, 4'hF, 32'h0,          1'b0},  // R3 top byte only
    '{1'b0, 32'h0000_0FE0, 4'hF, 32'h0,          1'b0}   // R2 word 0
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    int base;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 rd req idle", 128'(l1RdReq), 128'(0));
    chk("R1 wr req idle", 128'(l1WrReq), 128'(0));
    chk("R1 no stall idle", 128'(coreStall), 128'(0));

    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wd, VEC[i].miss,
            (i == 0) ? "R1/R4" : (VEC[i].we ? "R3" : (VEC[i].miss ? "R4" : "R2")), cyc);
    end

    // R5/R6: full buffer, sp line 0x100, farthest is 0x0FC0 (slot 3, dirty)
    rdLat = 2;
    wrLat = 3;
    base = logN;
    runOp(1'b0, 32'h0000_0FB0, 4'hF, 32'h0, 1'b1, "R5 dirty victim", cyc);
    chk("R5 one write-back", 128'(logN - base), 128'(1));
    chk("R5 victim address", 128'(logAddr[base]), 128'(32'h0000_0FC0));
    chk("R5 victim data", logData[base], refLine(32'h0000_0FC0));
    chk("R6 stall covers wb and fill", 128'(cyc >= wrLat + rdLat), 128'(1));

    // R5: sp moves down, farthest is now 0x0FF0 (slot 0, dirty)
    spIn = 32'h0000_0F80;
    base = logN;
    runOp(1'b0, 32'h0000_0F94, 4'hF, 32'h0, 1'b1, "R5 sp moved", cyc);
    chk("R5 sp-relative victim", 128'(logAddr[base]), 128'(32'h0000_0FF0));
    chk("R5 sp-relative data", logData[base], refLine(32'h0000_0FF0));

    // R5: sp back up, farthest is 0x0F90 (slot 0, clean) -> no write
    spIn = 32'h0000_1000;
    base = logN;
    runOp(1'b0, 32'h0000_0FA8, 4'hF, 32'h0, 1'b1, "R5 clean victim", cyc);
    chk("R5 clean victim dropped", 128'(logN - base), 128'(0));
    runOp(1'b0, 32'h0000_0FD4, 4'hF, 32'h0, 1'b0, "R5 survivor kept", cyc);

    // R7: slots 0:0FA0 1:0FE0(dirty) 2:0FD0 3:0FB0; dirty 0 and 3 too
    wrLat = 1;
    rdLat = 1;
    runOp(1'b1, 32'h0000_0FB4, 4'hF, 32'hDEAD_0003, 1'b0, "R3", cyc);
    runOp(1'b1, 32'h0000_0FAC, 4'h6, 32'h00C0_DE00, 1'b0, "R3", cyc);
    base = logN;
    @(negedge clk);
    spReload = 1'b1;
    spIn = 32'h0000_2000;
    @(negedge clk);
    spReload = 1'b0;
    runOp(1'b0, 32'h0000_0FD0, 4'hF, 32'h0, 1'b1, "R7 stall then refill", cyc);
    chk("R7 flush count", 128'(logN - base), 128'(3));
    chk("R7 order 1st", 128'(logAddr[base]),     128'(32'h0000_0FA0));
    chk("R7 order 2nd", 128'(logAddr[base + 1]), 128'(32'h0000_0FE0));
    chk("R7 order 3rd", 128'(logAddr[base + 2]), 128'(32'h0000_0FB0));
    chk("R7 data 2nd", logData[base + 1], refLine(32'h0000_0FE0));
    chk("R7 data 3rd", logData[base + 2], refLine(32'h0000_0FB0));
    runOp(1'b0, 32'h0000_0FE0, 4'hF, 32'h0, 1'b1, "R7 invalidated", cyc);
    runOp(1'b0, 32'h0000_0FD8, 4'hF, 32'h0, 1'b0, "R2 hit after refill", cyc);

    // R8: reload arrives during a slow fill
    runOp(1'b1, 32'h0000_0FE4, 4'hC, 32'h7777_0000, 1'b0, "R3", cyc);
    rdLat = 4;
    base = logN;
    fork
      doOp(1'b0, 32'h0000_0F04, 4'hF, 32'h0, cyc, rd);
      begin
        repeat (2) @(negedge clk);
        spReload = 1'b1;
        @(negedge clk);
        spReload = 1'b0;
      end
    join
    chk("R8 flush after fill", 128'(logN - base), 128'(1));
    chk("R8 flushed line", 128'(logAddr[base]), 128'(32'h0000_0FE0));
    chk("R8 flushed data", logData[base], refLine(32'h0000_0FE0));
    chk("R8 access data", 128'(rd), 128'(refLine(32'h0000_0F00)[63:32]));
    chk("R8 stall spans two fills", 128'(cyc >= 2 * rdLat), 128'(1));
    rdLat = 1;
    runOp(1'b0, 32'h0000_0FD0, 4'hF, 32'h0, 1'b1, "R8 buffer emptied", cyc);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule